// File: doc/BRIEF.md
# LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync and a data-enable window, plus two single-cycle event pulses (frame start and end of vertical sync) meant for an interrupt collector. It advances one dot on every clock cycle in which the dot enable is high. The horizontal geometry is programmed in character units of 8 dots and the vertical geometry in whole lines.

Software writes five registers through a simple write port: horizontal totals, horizontal sync placement, vertical totals, vertical sync placement, and a mode register holding the polarity controls. These writes go to a shadow copy. The working copy is refreshed at each frame boundary, so a frame never shows a mix of old and new geometry.

A run request starts and stops the raster. A 2-bit power status reports the result back. A stop lets the current frame finish before the outputs go idle.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the power status is 0, the counters are at the origin, and hsync, vsync, data-enable, frame-start and vsync-end are all low.
- R2: A write with `cfg_we` high uses `cfg_addr` to pick the register: 0 for horizontal totals (character total in bits 15:0, active characters in bits 31:16), 1 for horizontal sync (start character in bits 15:0, width in characters in bits 31:16), 2 for vertical totals (line total in bits 15:0, active lines in bits 31:16), 3 for vertical sync (start line in bits 15:0, width in lines in bits 31:16), and 4 for mode (bits 28..24).
- R3: A line lasts (character total × 8) dots and a frame lasts (line total) lines. Data-enable is active only while the character index is below the active-character count and the line index is below the active-line count.
- R4: Hsync is active while the character index lies in [start, start+width).
- R5: Vsync is active while the line index lies in [start line, start line+width).
- R6: Mode bit 28 inverts vsync and mode bit 27 inverts hsync. Mode bit 25 inverts data-enable. Mode bit 26 drives `wr_pol_o` and mode bit 24 drives `edge_pol_o`.
- R7: `frame_start_o` is high for exactly one cycle, in the cycle after a dot step wraps the raster back to the origin. It does not fire on the wrap that ends a stop.
- R8: `vsync_end_o` is high for exactly one cycle, in the cycle after a dot step enters line (start line + width − 1). It never fires when the vsync width is 0.
- R9: The counters advance only on cycles where `dot_en` is high and the status is 3 or 1. With `dot_en` low the outputs hold.
- R10: With the status at 0, a high `run_req` sets the status to 3 on the next cycle, with the raster at the origin.
- R11: While the status is 3, a low `run_req` sets the status to 1. The frame then completes, and at its wrap the status becomes 0 and the outputs go inactive. A high `run_req` while the status is 1 returns it to 3 without restarting the raster. Status value 2 never occurs.
- R12: While running, register writes take effect at the next frame wrap. A write in the same cycle as the wrap step applies to the new frame. While stopped, a write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot step enable |
| run_req | input | 1 | Start (1) / stop (0) request |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| edge_pol_o | output | 1 | Dot clock edge select level |
| wr_pol_o | output | 1 | Write strobe polarity level |
| frame_start_o | output | 1 | One-cycle frame-start event |
| vsync_end_o | output | 1 | One-cycle last-vsync-line event |
| pwr_st_o | output | 2 | Power status: 0 off, 1 stopping, 3 running |

## Verification
A register write and the frame-wrap dot step can land in the same clock cycle. The bench provokes this by raising `cfg_we` together with `dot_en` while the raster sits on the last dot of a frame. It judges the result by checking that `frame_start_o` pulses and that the hsync position written in that cycle already governs the new frame, at a character where the old setting would have given the opposite level. It also checks that the terminal wrap of a stop raises no frame-start pulse.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 8,
  parameter int LW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dot_en,
  input  logic        run_req,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        edge_pol_o,
  output logic        wr_pol_o,
  output logic        frame_start_o,
  output logic        vsync_end_o,
  output logic [1:0]  pwr_st_o
);

  localparam logic [1:0] PS_OFF = 2'd0, PS_DRAIN = 2'd1, PS_RUN = 2'd3;
  localparam logic [2:0] A_HTOT = 3'd0, A_HSYN = 3'd1, A_VTOT = 3'd2,
                         A_VSYN = 3'd3, A_MODE = 3'd4;
  localparam logic [CW:0]   H1 = 1;
  localparam logic [LW:0]   V1 = 1;
  localparam logic [CW-1:0] C1 = 1;
  localparam logic [LW-1:0] L1 = 1;

  typedef struct packed {
    logic [CW-1:0] htot, hdsp, hsp, hsw;
    logic [LW-1:0] vtot, vdsp, vsp, vsw;
    logic [4:0]    mode;
  } cfg_t;

  cfg_t sh, nx, act;
  logic [1:0]    pwr;
  logic [2:0]    sub;
  logic [CW-1:0] hc;
  logic [LW-1:0] ln, ln_nx;
  logic          fs_q, ve_q;
  logic          unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    nx = sh;
    if (cfg_we) begin
      case (cfg_addr)
        A_HTOT: begin nx.htot = cfg_wdata[CW-1:0]; nx.hdsp = cfg_wdata[16 +: CW]; end
        A_HSYN: begin nx.hsp  = cfg_wdata[CW-1:0]; nx.hsw  = cfg_wdata[16 +: CW]; end
        A_VTOT: begin nx.vtot = cfg_wdata[LW-1:0]; nx.vdsp = cfg_wdata[16 +: LW]; end
        A_VSYN: begin nx.vsp  = cfg_wdata[LW-1:0]; nx.vsw  = cfg_wdata[16 +: LW]; end
        A_MODE: nx.mode = cfg_wdata[28:24];
        default: ;
      endcase
    end
  end

  wire run      = pwr != PS_OFF;
  wire step     = run && dot_en;
  wire h_last   = ({1'b0, hc} + H1) >= {1'b0, act.htot};
  wire v_last   = ({1'b0, ln} + V1) >= {1'b0, act.vtot};
  wire last_dot = (sub == 3'd7) && h_last;
  wire wrap     = step && last_dot && v_last;
  wire halt     = (pwr == PS_DRAIN) && !run_req;
  wire load     = !run || wrap;
  wire [LW:0] vend = {1'b0, act.vsp} + {1'b0, act.vsw} - V1;

  assign ln_nx = v_last ? '0 : ln + L1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      act  <= '0;
      pwr  <= PS_OFF;
      sub  <= '0;
      hc   <= '0;
      ln   <= '0;
      fs_q <= 1'b0;
      ve_q <= 1'b0;
    end else begin
      sh   <= nx;
      if (load) act <= nx;
      fs_q <= wrap && !halt;
      ve_q <= step && last_dot && (act.vsw != '0) && ({1'b0, ln_nx} == vend);
      if (step) begin
        sub <= sub + 3'd1;
        if (sub == 3'd7) begin
          if (h_last) begin
            hc <= '0;
            ln <= ln_nx;
          end else begin
            hc <= hc + C1;
          end
        end
      end
      case (pwr)
        PS_OFF:   if (run_req) pwr <= PS_RUN;
        PS_RUN:   if (!run_req) pwr <= PS_DRAIN;
        PS_DRAIN: if (run_req) pwr <= PS_RUN;
                  else if (wrap) pwr <= PS_OFF;
        default:  pwr <= PS_OFF;
      endcase
    end
  end

  wire hs_act = run && ({1'b0, hc} >= {1'b0, act.hsp}) &&
                ({1'b0, hc} < ({1'b0, act.hsp} + {1'b0, act.hsw}));
  wire vs_act = run && ({1'b0, ln} >= {1'b0, act.vsp}) &&
                ({1'b0, ln} < ({1'b0, act.vsp} + {1'b0, act.vsw}));
  wire de_act = run && (hc < act.hdsp) && (ln < act.vdsp);

  assign hsync_o       = hs_act ^ act.mode[3];
  assign vsync_o       = vs_act ^ act.mode[4];
  assign de_o          = de_act ^ act.mode[1];
  assign wr_pol_o      = act.mode[2];
  assign edge_pol_o    = act.mode[0];
  assign frame_start_o = fs_q;
  assign vsync_end_o   = ve_q;
  assign pwr_st_o      = pwr;

  a_r7_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable({ln, hc, sub}));
  a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_st_o == PS_OFF && run_req) |=> (pwr_st_o == PS_RUN));
  a_r11_run_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_st_o == PS_RUN) |=> (pwr_st_o == PS_RUN || pwr_st_o == PS_DRAIN));
  a_r11_no_code2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_st_o != 2'd2);
  a_r11_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_st_o == PS_OFF) |-> ({ln, hc, sub} == '0 && !frame_start_o));

endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, dot_en = 1'b0, run_req = 1'b0, cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic hs, vs, de, epol, wpol, fs, ve;
  logic [1:0] pwr;
  int n_run = 0, n_fail = 0, cur = 0;

  always #5 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .run_req(run_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .edge_pol_o(epol), .wr_pol_o(wpol),
    .frame_start_o(fs), .vsync_end_o(ve), .pwr_st_o(pwr)
  );

  // frame: 4 chars x 8 dots x 5 lines = 160 dots; {pos, hs, vs, de, fs, ve}
  localparam logic [15:0] VEC [12] = '{
    {11'd0,   5'b00100}, {11'd15,  5'b00100}, {11'd16,  5'b00000},
    {11'd24,  5'b10000}, {11'd31,  5'b10000}, {11'd32,  5'b00100},
    {11'd95,  5'b10000}, {11'd96,  5'b01000}, {11'd127, 5'b11000},
    {11'd128, 5'b01001}, {11'd159, 5'b11000}, {11'd160, 5'b00110}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) begin dot_en = 1'b1; @(negedge clk); end
    dot_en = 1'b0;
    cur += n;
  endtask

  task automatic idle(input int n);
    dot_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "pwr", pwr, 0);
    chk("R1", "hs/vs/de", {hs, vs, de}, 3'b000);
    chk("R1", "fs/ve", {fs, ve}, 2'b00);

    // R2 register layout
    wr(3'd0, {16'd2, 16'd4});
    wr(3'd1, {16'd1, 16'd3});
    wr(3'd2, {16'd3, 16'd5});
    wr(3'd3, {16'd2, 16'd3});
    wr(3'd4, 32'h0);

    run_req = 1'b1;
    idle(1);
    chk("R10", "pwr after start", pwr, 3);

    for (int i = 0; i < 12; i++) begin
      int tgt;
      tgt = int'(VEC[i][15:5]);
      steps(tgt - cur);
      chk("R4", $sformatf("hs@%0d", tgt), hs, VEC[i][4]);
      chk("R5", $sformatf("vs@%0d", tgt), vs, VEC[i][3]);
      chk("R3", $sformatf("de@%0d", tgt), de, VEC[i][2]);
      chk("R7", $sformatf("fs@%0d", tgt), fs, VEC[i][1]);
      chk("R8", $sformatf("ve@%0d", tgt), ve, VEC[i][0]);
    end

    // R9 dot enable freeze
    steps(15);
    idle(4);
    chk("R9", "de held", de, 1);
    steps(1);
    chk("R9", "de after one step", de, 0);

    // R12 mid-frame write deferred
    wr(3'd1, {16'd1, 16'd2});
    chk("R12", "hs unchanged now", hs, 0);
    steps(32);
    chk("R12", "hs same frame old", hs, 0);
    steps(112);
    chk("R7", "fs at wrap", fs, 1);
    steps(16);
    chk("R12", "hs new frame", hs, 1);

    // R12 write coinciding with wrap step
    steps(143);
    dot_en = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = {16'd1, 16'd1};
    @(negedge clk);
    cfg_we = 1'b0; dot_en = 1'b0;
    chk("R7", "fs coincident wrap", fs, 1);
    steps(8);
    chk("R2,R12", "hs coincident write", hs, 1);

    // R6 polarity
    wr(3'd4, 32'h1F00_0000);
    chk("R6", "hs before boundary", hs, 1);
    chk("R6", "edge before boundary", epol, 0);
    steps(152);
    chk("R6", "hs/vs/de inverted", {hs, vs, de}, 3'b110);
    chk("R6", "edge/wr pol", {epol, wpol}, 2'b11);

    // R11 stop handshake
    steps(20);
    run_req = 1'b0;
    idle(1);
    chk("R11", "pwr draining", pwr, 1);
    steps(139);
    chk("R11", "pwr before wrap", pwr, 1);
    steps(1);
    chk("R11", "pwr off", pwr, 0);
    chk("R7", "no fs on stop", fs, 0);
    chk("R11", "idle inverted", {hs, vs, de}, 3'b111);
    wr(3'd4, 32'h0);
    chk("R12", "stopped write immediate", {hs, vs, de, epol}, 4'b0000);

    // R11 abort stop
    cur = 0;
    run_req = 1'b1;
    idle(1);
    chk("R10", "pwr restart", pwr, 3);
    steps(10);
    chk("R3", "de pos10", de, 1);
    run_req = 1'b0;
    idle(1);
    chk("R11", "pwr draining 2", pwr, 1);
    run_req = 1'b1;
    idle(1);
    chk("R11", "pwr back to run", pwr, 3);
    steps(6);
    chk("R11", "raster continued", de, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule